// File: doc/BRIEF.md
# Segmented Comparand Loader with Rotator

This block builds a 64-bit search key, the comparand, out of 16-bit words that arrive one per write on a narrow data port. A write-side segment pointer decides which quarter of the key each incoming word replaces. A separate read-side pointer decides which quarter is shown on the read port. Both pointers step through a programmable window of segment indices. When a pointer passes the window's last index, it wraps to the first.

When the word that completes the window is written, the block raises a one-cycle compare request toward the associative array. No separate command is needed. Between loads, the whole key can be rotated by one bit toward the MSB or toward the LSB. This lets a search be repeated on shifted data.

The key is presented in parallel on a 64-bit output for the array to use.

Top module: `cmpl_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the key becomes all zeros. Both pointers also load `seg_lo`, so after reset `rd_data` shows segment `seg_lo` and the next write lands in segment `seg_lo`.
- R2: A write (`wr_en` high) replaces key bits [16*i+15:16*i] with `wr_data`, where i is the write pointer. The other 48 bits are unchanged. The new key is visible after that edge.
- R3: Each write advances the write pointer. If the pointer equals `seg_hi`, it becomes `seg_lo`. Otherwise it becomes pointer+1 modulo 4. Without a write, the pointer holds.
- R4: `rd_data` combinationally shows key segment j, where j is the read pointer. Each `rd_en` advances the read pointer by the rule of R3. Otherwise the read pointer holds. It is independent of the write pointer.
- R5: `cmp_req` is high for exactly the one cycle after an edge at which a write occurred with the write pointer equal to `seg_hi`. At all other times it is low.
- R6: With `shl` high, `shr` low and no write, the key rotates left by one: bit 63 enters bit 0.
- R7: With `shr` high, `shl` low and no write, the key rotates right by one: bit 0 enters bit 63.
- R8: With `shl` and `shr` both high and no write, the key is unchanged.
- R9: A write in the same cycle as `shl` or `shr` performs only the write. The shift request has no effect.
- R10: `rd_en` alone never changes the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one 16-bit word into the key |
| wr_data | input | 16 | Word to write |
| rd_en | input | 1 | Advance the read pointer |
| shl | input | 1 | Rotate key left by one bit |
| shr | input | 1 | Rotate key right by one bit |
| seg_lo | input | 2 | First segment index of the pointer window |
| seg_hi | input | 2 | Last segment index of the pointer window |
| cmp_word | output | 64 | Assembled key |
| rd_data | output | 16 | Key segment at the read pointer |
| cmp_req | output | 1 | One-cycle compare request |

## Verification
Two kinds of collision are the critical cases. The first is a load colliding with a rotate command in the same cycle. The second is a read-pointer advance in the same cycle that a terminal write fires a compare. The random phase draws write, read, and both shift strobes independently each cycle, so these overlaps occur often. Directed cycles also force each overlap once. A bench reference model predicts the key, both pointers, and the request pulse. The outputs are judged against that model one edge later. A write that coincides with a rotate must show only the written word, with no rotation.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
    localparam int SEG_W   = 16;
    localparam int N_SEG   = 4;
    localparam int KEY_W   = SEG_W * N_SEG;
    localparam int IDX_W   = $clog2(N_SEG);

    typedef logic [IDX_W-1:0] seg_idx_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [KEY_W-1:0] key_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_ROL  = 2'd2,
        OP_ROR  = 2'd3
    } key_op_t;

    function automatic seg_idx_t next_seg(seg_idx_t cur, seg_idx_t lo, seg_idx_t hi);
        if (cur == hi) return lo;
        return seg_idx_t'(cur + 1'b1);
    endfunction

    function automatic key_t rol1(key_t k);
        return {k[KEY_W-2:0], k[KEY_W-1]};
    endfunction

    function automatic key_t ror1(key_t k);
        return {k[0], k[KEY_W-1:1]};
    endfunction

    function automatic seg_t pick_seg(key_t k, seg_idx_t i);
        return k[i*SEG_W +: SEG_W];
    endfunction
endpackage

// File: rtl/cmpl_seg_ctr.sv
module cmpl_seg_ctr
    import cmpl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  seg_idx_t lo,
    input  seg_idx_t hi,
    output seg_idx_t idx
);
    always_ff @(posedge clk) begin
        if (rst)      idx <= lo;
        else if (adv) idx <= next_seg(idx, lo, hi);
    end

    AST_CTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && idx == hi) |=> (idx == $past(lo))); // R3
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && idx != hi) |=> (idx == seg_idx_t'($past(idx) + 1'b1))); // R3
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> $stable(idx)); // R4
endmodule

// File: rtl/cmpl_key_reg.sv
module cmpl_key_reg
    import cmpl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  seg_idx_t wr_idx,
    input  seg_t     wr_data,
    input  logic     shl,
    input  logic     shr,
    output key_t     key
);
    key_op_t op;
    key_t    key_nxt;

    always_comb begin
        if (wr_en)            op = OP_LOAD;
        else if (shl && !shr) op = OP_ROL;
        else if (shr && !shl) op = OP_ROR;
        else                  op = OP_HOLD;
    end

    always_comb begin
        key_nxt = key;
        unique case (op)
            OP_LOAD: key_nxt[wr_idx*SEG_W +: SEG_W] = wr_data;
            OP_ROL:  key_nxt = rol1(key);
            OP_ROR:  key_nxt = ror1(key);
            default: key_nxt = key;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) key <= '0;
        else     key <= key_nxt;
    end

    AST_LOAD_SEG: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pick_seg(key, $past(wr_idx)) == $past(wr_data))); // R2
    AST_ROT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && shl && !shr) |=> (key[0] == $past(key[KEY_W-1]) && key[KEY_W-1:1] == $past(key[KEY_W-2:0]))); // R6
    AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && shr && !shl) |=> (key[KEY_W-1] == $past(key[0]) && key[KEY_W-2:0] == $past(key[KEY_W-1:1]))); // R7
    AST_BOTH_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && shl && shr) |=> $stable(key)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !shl && !shr) |=> $stable(key)); // R10
endmodule

// File: rtl/cmpl_loader.sv
module cmpl_loader
    import cmpl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    input  logic        shl,
    input  logic        shr,
    input  logic [1:0]  seg_lo,
    input  logic [1:0]  seg_hi,
    output logic [63:0] cmp_word,
    output logic [15:0] rd_data,
    output logic        cmp_req
);
    seg_idx_t wr_idx;
    seg_idx_t rd_idx;
    key_t     key;
    logic     term_wr;

    cmpl_seg_ctr u_wr_ctr (
        .clk(clk), .rst(rst), .adv(wr_en),
        .lo(seg_lo), .hi(seg_hi), .idx(wr_idx)
    );

    cmpl_seg_ctr u_rd_ctr (
        .clk(clk), .rst(rst), .adv(rd_en),
        .lo(seg_lo), .hi(seg_hi), .idx(rd_idx)
    );

    cmpl_key_reg u_key (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .shl(shl), .shr(shr), .key(key)
    );

    assign term_wr  = wr_en && (wr_idx == seg_hi);
    assign cmp_word = key;
    assign rd_data  = pick_seg(key, rd_idx);

    always_ff @(posedge clk) begin
        if (rst) cmp_req <= 1'b0;
        else     cmp_req <= term_wr;
    end

    AST_REQ_FIRES: assert property (@(posedge clk) disable iff (rst)
        term_wr |=> cmp_req); // R5
    AST_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !term_wr |=> !cmp_req); // R5
    AST_RD_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !shl && !shr) |=> $stable(cmp_word)); // R10
endmodule

// File: tb/cmpl_loader_tb.sv
module cmpl_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        shl = 1'b0;
    logic        shr = 1'b0;
    logic [1:0]  seg_lo = 2'd0;
    logic [1:0]  seg_hi = 2'd3;
    logic [63:0] cmp_word;
    logic [15:0] rd_data;
    logic        cmp_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [63:0] m_key = '0;
    logic [1:0]  m_wp = 2'd0;
    logic [1:0]  m_rp = 2'd0;
    logic        m_req = 1'b0;
    string       key_tag = "R1";

    always #2.5 clk = ~clk;

    cmpl_loader u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .shl(shl), .shr(shr), .seg_lo(seg_lo), .seg_hi(seg_hi),
        .cmp_word(cmp_word), .rd_data(rd_data), .cmp_req(cmp_req)
    );

    function automatic logic [1:0] m_next(logic [1:0] p, logic [1:0] lo, logic [1:0] hi);
        return (p == hi) ? lo : p + 2'd1;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(key_tag, cmp_word, m_key);
        chk("R4", {48'd0, rd_data}, {48'd0, m_key[m_rp*16 +: 16]});
        chk("R5", {63'd0, cmp_req}, {63'd0, m_req});
    endtask

    task automatic do_reset(logic [1:0] lo, logic [1:0] hi);
        seg_lo = lo; seg_hi = hi;
        rst = 1'b1; wr_en = 0; rd_en = 0; shl = 0; shr = 0;
        @(negedge clk);
        rst = 1'b0;
        m_key = '0; m_wp = lo; m_rp = lo; m_req = 1'b0; key_tag = "R1";
        check_all();
    endtask

    task automatic cyc(logic w, logic [15:0] d, logic r, logic sl, logic sr);
        wr_en = w; wr_data = d; rd_en = r; shl = sl; shr = sr;
        m_req = w && (m_wp == seg_hi);
        if (w) begin
            m_key[m_wp*16 +: 16] = d;
            key_tag = (sl || sr) ? "R9" : "R2";
            m_wp = m_next(m_wp, seg_lo, seg_hi);
        end else if (sl && !sr) begin
            m_key = {m_key[62:0], m_key[63]}; key_tag = "R6";
        end else if (sr && !sl) begin
            m_key = {m_key[0], m_key[63:1]}; key_tag = "R7";
        end else if (sl && sr) begin
            key_tag = "R8";
        end else begin
            key_tag = "R10";
        end
        if (r) m_rp = m_next(m_rp, seg_lo, seg_hi);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        do_reset(2'd0, 2'd3);
        // R2 R3 R5: fill the full window, compare fires on the fourth write
        cyc(1, 16'h1111, 0, 0, 0);
        cyc(1, 16'h2222, 0, 0, 0);
        cyc(1, 16'h3333, 0, 0, 0);
        cyc(1, 16'h8444, 1, 0, 0); // R5 with a coincident read advance
        cyc(0, 16'h0, 0, 0, 0);
        // R6 R7 R8
        cyc(0, 16'h0, 0, 1, 0);
        cyc(0, 16'h0, 0, 0, 1);
        cyc(0, 16'h0, 0, 1, 1);
        // R9: write collides with each rotate
        cyc(1, 16'hABCD, 0, 1, 0);
        cyc(1, 16'h1234, 0, 0, 1);
        // R4 R10: read wraps through all segments without touching key
        for (int i = 0; i < 5; i++) cyc(0, 16'h0, 1, 0, 0);
        // R3: narrow window 1..2
        do_reset(2'd1, 2'd2);
        for (int i = 0; i < 5; i++) cyc(1, 16'h5A00 + 16'(i), 1, 0, 0);
        // R5: single-segment window fires on every write
        do_reset(2'd3, 2'd3);
        for (int i = 0; i < 3; i++) cyc(1, 16'hC0DE ^ 16'(i), 0, 0, 0);
        // random phase
        do_reset(2'd0, 2'd3);
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 499) do_reset(2'($urandom), 2'($urandom));
            else cyc(($urandom % 3) == 0, 16'($urandom), ($urandom % 3) == 0,
                     ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule